// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Block

This block holds the programmable state of an interrupt router behind a small memory-mapped window. Software sees only two directly addressed words. The first is a 32-bit select register. The second is a data window. The value in the select register decides what the window reaches: a fixed identification register, a read-only version word, an arbitration word, or one half of a 64-bit routing entry. There is one routing entry for each interrupt input pin.

The whole table goes out in parallel to the delivery logic. That logic lives outside this block and reports back when it has accepted a level-triggered request. The block then records that acceptance in the entry's remote-request status bit. Each time a software write flips an entry's mask bit, the block raises a one-cycle notification that names the entry and carries the new mask value.

Top module: `irq_route_regs`

## Requirements
- R1: A 4- or 8-byte write to direct offset 0x00 loads all 32 bits of the select register, and a read at offset 0x00 returns it. Offset 0x10 is the data window. Only address bits 7:0 are decoded, so higher address bits have no effect.
- R2: With select = 0x01, a window read returns (pin count − 1) in bits 23:16 and the version code 0x11 in bits 7:0, which is 0x00170011 for 24 pins. A window write at this select value changes nothing.
- R3: With select = 0x00, a window write stores data bits 27:24 as a 4-bit ID, and a window read returns that ID in bits 27:24 with all other bits zero. With select = 0x02, a window read returns the same ID word, and a window write is ignored.
- R4: Any select value other than 0x00–0x02 addresses entry index (select − 0x10) >> 1, computed modulo 2^32. An odd select value reaches entry bits 63:32 and an even value reaches bits 31:0. Entry fields: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote request 14, trigger 15 (1 = level), mask 16, destination 63:56.
- R5: A window write whose computed index is 24 or more is discarded, and a window read with that index returns 0.
- R6: Writes are taken only when the size input is 4 or 8 bytes, and only the low 32 data bits are used. A write of any other size changes no state.
- R7: A lower-half write clears the entry's remote-request bit (14), whatever the written data holds there. An upper-half write leaves it unchanged. A pulse on an entry's accept input sets bit 14 only when bit 15 is 1. If the pulse comes in the same cycle as a lower-half write to that entry, the clear wins.
- R8: When a write changes an entry's mask bit (16), the notification valid output is high for exactly the cycle after that write, with the entry index and the new mask value. A write that leaves the mask unchanged raises no notification.
- R9: Synchronous active-low reset sets every entry to 0x0000000000010000 (masked), and clears the select register, the ID and the notification.
- R10: A direct access whose address bits 3:0 are nonzero, or whose bits 7:0 are neither 0x00 nor 0x10, reads 0 and its write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Direct byte address; only bits 7:0 are decoded |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data; bits 31:0 are used |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| rirr_set | input | PINS | Per-entry pulse from delivery: a level request was accepted |
| tbl_flat | output | PINS*64 | All entries, entry i at bits i*64 +: 64 |
| mask_ntf_vld | output | 1 | One-cycle mask-change notification |
| mask_ntf_idx | output | IDX_W | Entry whose mask changed |
| mask_ntf_val | output | 1 | New mask value |

## Verification
On every cycle, assertions check four things. The remote-request bit is cleared after a lower-half write and kept after an upper-half write. A notification always matches the mask now stored in the named entry. Writes of the wrong size, to the arbitration word, or to an out-of-range index leave the state unchanged. Only the bench's scenarios can show the actual read values (version word, ID placement, half selection, the modulo-2^32 index wrap) and the full table image, which the behavioural model compares on each clock.

// File: rtl/irq_route_pkg.sv
// Shared constants for the interrupt routing register block.
// Assumes 64-bit entries reached as two 32-bit halves.
package irq_route_pkg;
    // Direct offsets (low 8 address bits)
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;

    // Select codes for fixed registers
    localparam logic [31:0] SEL_ID  = 32'h0;
    localparam logic [31:0] SEL_VER = 32'h1;
    localparam logic [31:0] SEL_ARB = 32'h2;
    localparam logic [31:0] SEL_TBL_BASE = 32'h10;

    // Entry field positions
    localparam int F_RIRR = 14;
    localparam int F_TRIG = 15;
    localparam int F_MASK = 16;

    localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SEL  = 2'd1,
        TGT_WIN  = 2'd2
    } tgt_e;
endpackage

// File: rtl/irq_route_decode.sv
// Direct address decode and access-size qualification.
// Assumes the base-address match is done outside; only bits 7:0 matter.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    output tgt_e              tgt,
    output logic              size_ok
);
    logic [7:0] off8;
    logic       unused_hi;

    assign off8      = addr[7:0];
    assign unused_hi = ^addr[ADDR_W-1:8];

    // Pick the directly addressed register; misaligned goes nowhere.
    always_comb begin
        tgt = TGT_NONE;
        if (off8[3:0] == 4'h0) begin
            if (off8 == OFF_SEL)      tgt = TGT_SEL;
            else if (off8 == OFF_WIN) tgt = TGT_WIN;
        end
    end

    // Only word and double-word writes are honoured.
    assign size_ok = (size == 4'd4) || (size == 4'd8);
endmodule

// File: rtl/irq_route_index.sv
// Classifies the select register: fixed register or table half.
// Assumes index arithmetic wraps modulo 2^32.
module irq_route_index
    import irq_route_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input  logic [31:0]      sel,
    output logic             is_id,
    output logic             is_ver,
    output logic             is_arb,
    output logic             tbl_hit,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);
    logic [31:0] idx_full;

    // Decode fixed select codes.
    always_comb begin
        is_id  = (sel == SEL_ID);
        is_ver = (sel == SEL_VER);
        is_arb = (sel == SEL_ARB);
    end

    // Entry index and half for all other codes.
    always_comb begin
        idx_full = (sel - SEL_TBL_BASE) >> 1;
        tbl_hit  = !(is_id || is_ver || is_arb) && (idx_full < 32'(PINS));
        idx      = idx_full[IDX_W-1:0];
        hi       = sel[0];
    end
endmodule

// File: rtl/irq_route_table.sv
// Storage for the routing entries, remote-request tracking and the
// mask-change notification. Assumes widx/ridx come with a valid hit.
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               we_hi,
    input  logic [IDX_W-1:0]   widx,
    input  logic [31:0]        wdata,
    input  logic [PINS-1:0]    rirr_set,
    input  logic [IDX_W-1:0]   ridx,
    input  logic               rhi,
    output logic [31:0]        rhalf,
    output logic [PINS*64-1:0] tbl_flat,
    output logic               ntf_vld,
    output logic [IDX_W-1:0]   ntf_idx,
    output logic               ntf_val
);
    logic [63:0] ent [PINS];

    for (genvar i = 0; i < PINS; i++) begin : g_ent
        logic we_lo_i;
        logic we_hi_i;
        assign we_lo_i = we && !we_hi && (int'(widx) == i);
        assign we_hi_i = we && we_hi && (int'(widx) == i);

        // Entry update: software halves, then accept-driven status set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[i] <= ENTRY_RST;
            end else begin
                if (we_hi_i) ent[i][63:32] <= wdata;
                if (we_lo_i) begin
                    ent[i][31:0]   <= wdata;
                    ent[i][F_RIRR] <= 1'b0;
                end else if (rirr_set[i] && ent[i][F_TRIG]) begin
                    ent[i][F_RIRR] <= 1'b1;
                end
            end
        end

        assign tbl_flat[i*64 +: 64] = ent[i];

        // R7
        rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we_lo_i |=> !ent[i][F_RIRR]);
        // R7
        rirr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we_hi_i && !rirr_set[i] |=> $stable(ent[i][F_RIRR]));
    end

    // Read one half of the addressed entry.
    always_comb begin
        rhalf = 32'h0;
        if (int'(ridx) < PINS) rhalf = rhi ? ent[ridx][63:32] : ent[ridx][31:0];
    end

    // Flag a mask flip caused by a lower-half write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntf_vld <= 1'b0;
            ntf_idx <= '0;
            ntf_val <= 1'b0;
        end else begin
            ntf_vld <= we && !we_hi && (int'(widx) < PINS)
                       && (ent[widx][F_MASK] != wdata[F_MASK]);
            ntf_idx <= widx;
            ntf_val <= wdata[F_MASK];
        end
    end

    // R8
    ntf_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_vld |-> (int'(ntf_idx) < PINS) && (ent[ntf_idx][F_MASK] == ntf_val));
endmodule

// File: rtl/irq_route_regs.sv
// Top of the routing register block: select register, ID register,
// window read mux and the entry table. Assumes one access per cycle.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          PINS   = 24,
    parameter logic [7:0]  VER_ID = 8'h11,
    localparam int         IDX_W  = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_size,
    input  logic [63:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [PINS-1:0]    rirr_set,
    output logic [PINS*64-1:0] tbl_flat,
    output logic               mask_ntf_vld,
    output logic [IDX_W-1:0]   mask_ntf_idx,
    output logic               mask_ntf_val
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(PINS - 1), 8'h00, VER_ID};

    tgt_e             tgt;
    logic             size_ok;
    logic [31:0]      sel_q;
    logic [3:0]       id_q;
    logic             is_id, is_ver, is_arb, tbl_hit, hi;
    logic [IDX_W-1:0] idx;
    logic [31:0]      rhalf;
    logic             wr_ok, win_wr;
    logic             unused_wd;

    assign unused_wd = ^bus_wdata[63:32];

    irq_route_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .size(bus_size), .tgt(tgt), .size_ok(size_ok)
    );

    irq_route_index #(.PINS(PINS), .IDX_W(IDX_W)) u_idx (
        .sel(sel_q), .is_id(is_id), .is_ver(is_ver), .is_arb(is_arb),
        .tbl_hit(tbl_hit), .idx(idx), .hi(hi)
    );

    assign wr_ok  = bus_wr && size_ok;
    assign win_wr = wr_ok && (tgt == TGT_WIN);

    // Select register load.
    always_ff @(posedge clk) begin
        if (!rst_n)                           sel_q <= 32'h0;
        else if (wr_ok && (tgt == TGT_SEL))   sel_q <= bus_wdata[31:0];
    end

    // ID register load through the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                 id_q <= 4'h0;
        else if (win_wr && is_id)   id_q <= bus_wdata[27:24];
    end

    irq_route_table #(.PINS(PINS), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(win_wr && tbl_hit), .we_hi(hi), .widx(idx), .wdata(bus_wdata[31:0]),
        .rirr_set(rirr_set), .ridx(idx), .rhi(hi), .rhalf(rhalf),
        .tbl_flat(tbl_flat),
        .ntf_vld(mask_ntf_vld), .ntf_idx(mask_ntf_idx), .ntf_val(mask_ntf_val)
    );

    // Read data for the current direct address.
    always_comb begin
        bus_rdata = 32'h0;
        case (tgt)
            TGT_SEL: bus_rdata = sel_q;
            TGT_WIN: begin
                if (is_id || is_arb) bus_rdata = {4'h0, id_q, 24'h0};
                else if (is_ver)     bus_rdata = VER_WORD;
                else if (tbl_hit)    bus_rdata = rhalf;
            end
            default: bus_rdata = 32'h0;
        endcase
    end

    // R6
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !size_ok |=> $stable(sel_q) && $stable(id_q));
    // R3
    arb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr && is_arb |=> $stable(id_q));
    // R5
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr && !(is_id || is_ver || is_arb) && !tbl_hit |=> $stable(tbl_flat));
endmodule

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb;
    localparam int NP = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [31:0]    bus_addr = '0;
    logic [3:0]     bus_size = 4'd4;
    logic [63:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NP-1:0]  rirr_set = '0;
    logic [NP*64-1:0] tbl_flat;
    logic           mask_ntf_vld;
    logic [4:0]     mask_ntf_idx;
    logic           mask_ntf_val;

    int errors = 0;
    int checks = 0;
    string cur_req = "R9";
    bit done = 0;

    always #2 clk = ~clk;

    irq_route_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rirr_set(rirr_set), .tbl_flat(tbl_flat), .mask_ntf_vld(mask_ntf_vld),
        .mask_ntf_idx(mask_ntf_idx), .mask_ntf_val(mask_ntf_val)
    );

    // Behavioural reference state
    logic [63:0] m_ent [NP];
    logic [31:0] m_sel;
    logic [3:0]  m_id;
    bit          m_nv;
    int          m_ni;
    bit          m_nval;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [31:0] a);
        logic [31:0] t;
        if (a[3:0] != 0) return 0;
        if (a[7:0] == 8'h00) return m_sel;
        if (a[7:0] != 8'h10) return 0;
        if (m_sel == 0 || m_sel == 2) return {4'h0, m_id, 24'h0};
        if (m_sel == 1) return 32'h0017_0011;
        t = (m_sel - 32'h10) >> 1;
        if (t >= NP) return 0;
        return m_sel[0] ? m_ent[t][63:32] : m_ent[t][31:0];
    endfunction

    // Reference model step and per-cycle comparison.
    always @(posedge clk) begin
        logic [63:0] nxt [NP];
        bit lowi [NP];
        logic [31:0] d, t;
        logic [NP*64-1:0] flat;
        bit old_m;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) m_ent[i] = 64'h1_0000;
            m_sel = 0; m_id = 0; m_nv = 0; m_ni = 0; m_nval = 0;
        end else begin
            for (int i = 0; i < NP; i++) begin nxt[i] = m_ent[i]; lowi[i] = 0; end
            m_nv = 0;
            d = bus_wdata[31:0];
            if (bus_wr && (bus_size == 4 || bus_size == 8) && bus_addr[3:0] == 0) begin
                if (bus_addr[7:0] == 8'h00) m_sel = d;
                else if (bus_addr[7:0] == 8'h10) begin
                    if (m_sel == 0) m_id = d[27:24];
                    else if (m_sel != 1 && m_sel != 2) begin
                        t = (m_sel - 32'h10) >> 1;
                        if (t < NP) begin
                            if (m_sel[0]) nxt[t][63:32] = d;
                            else begin
                                old_m = m_ent[t][16];
                                nxt[t][31:0] = d;
                                nxt[t][14] = 0;
                                lowi[t] = 1;
                                if (d[16] != old_m) begin
                                    m_nv = 1; m_ni = int'(t); m_nval = d[16];
                                end
                            end
                        end
                    end
                end
            end
            for (int i = 0; i < NP; i++)
                if (rirr_set[i] && m_ent[i][15] && !lowi[i]) nxt[i][14] = 1;
            for (int i = 0; i < NP; i++) m_ent[i] = nxt[i];
        end
        #1;
        for (int i = 0; i < NP; i++) flat[i*64 +: 64] = m_ent[i];
        chk({cur_req, " rdata"}, {32'h0, bus_rdata}, {32'h0, m_read(bus_addr)});
        checks++;
        if (tbl_flat !== flat) begin
            errors++;
            $display("FAIL %s table: got %h expected %h", cur_req, tbl_flat, flat);
        end
        chk({cur_req, " ntf_vld"}, {63'h0, mask_ntf_vld}, {63'h0, m_nv});
        if (m_nv) begin
            chk("R8 ntf_idx", {59'h0, mask_ntf_idx}, 64'(m_ni));
            chk("R8 ntf_val", {63'h0, mask_ntf_val}, {63'h0, m_nval});
        end
    end

    task automatic wr(input logic [31:0] a, input logic [3:0] sz, input logic [63:0] dat);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = dat; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        rirr_set[i] = 1'b1;
        @(negedge clk);
        rirr_set = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        rd(32'h00, v); chk("R9 select", {32'h0, v}, 64'h0);
        rd(32'h10, v); chk("R9 id", {32'h0, v}, 64'h0);
        chk("R9 masks", {63'h0, &{tbl_flat[16], tbl_flat[23*64+16]}}, 64'h1);
        // R1
        cur_req = "R1";
        wr(32'h00, 4, 64'h1234_5678); rd(32'h00, v);
        chk("R1 select", {32'h0, v}, 64'h1234_5678);
        rd(32'hABCD_0100, v); chk("R1 upper bits", {32'h0, v}, 64'h1234_5678);
        // R2
        cur_req = "R2";
        wr(32'h00, 8, 64'hDEAD_BEEF_0000_0001);
        rd(32'h10, v); chk("R2 version", {32'h0, v}, 64'h0017_0011);
        wr(32'h10, 4, 64'hFFFF_FFFF);
        rd(32'h10, v); chk("R2 version write", {32'h0, v}, 64'h0017_0011);
        // R3
        cur_req = "R3";
        wr(32'h00, 4, 0); wr(32'h10, 4, 64'hA500_0000);
        rd(32'h10, v); chk("R3 id", {32'h0, v}, 64'h0500_0000);
        wr(32'h00, 4, 2);
        rd(32'h10, v); chk("R3 arb read", {32'h0, v}, 64'h0500_0000);
        wr(32'h10, 4, 64'h0F00_0000);
        wr(32'h00, 4, 0);
        rd(32'h10, v); chk("R3 arb write", {32'h0, v}, 64'h0500_0000);
        // R4 and R8
        cur_req = "R4";
        wr(32'h00, 4, 32'h10); wr(32'h10, 4, 64'h0000_A031);
        chk("R8 notify unmask", {61'h0, mask_ntf_vld, mask_ntf_val, mask_ntf_idx == 0}, 64'h5);
        wr(32'h00, 4, 32'h11); wr(32'h10, 4, 64'hFF00_0000);
        chk("R4 entry0", tbl_flat[63:0], 64'hFF00_0000_0000_A031);
        wr(32'h00, 4, 32'h3E); wr(32'h10, 8, 64'h0001_8042);
        chk("R8 no notify", {63'h0, mask_ntf_vld}, 64'h0);
        wr(32'h00, 4, 32'h3F); wr(32'h10, 4, 64'h0F00_0000);
        rd(32'h10, v); chk("R4 entry23 hi", {32'h0, v}, 64'h0F00_0000);
        chk("R4 entry23", tbl_flat[23*64 +: 64], 64'h0F00_0000_0001_8042);
        // R5
        cur_req = "R5";
        wr(32'h00, 4, 32'h40); wr(32'h10, 4, 64'h1234);
        rd(32'h10, v); chk("R5 oob read", {32'h0, v}, 64'h0);
        wr(32'h00, 4, 32'h05); wr(32'h10, 4, 64'h5555);
        rd(32'h10, v); chk("R5 wrap read", {32'h0, v}, 64'h0);
        // R6
        cur_req = "R6";
        wr(32'h00, 2, 64'h77); rd(32'h00, v);
        chk("R6 size2 dropped", {32'h0, v}, 64'h5);
        // R7
        cur_req = "R7";
        wr(32'h00, 4, 32'h1A); wr(32'h10, 4, 64'h0000_C000);
        rd(32'h10, v); chk("R7 low write clears", {32'h0, v}, 64'h0000_8000);
        pulse(5); rd(32'h10, v); chk("R7 set level", {32'h0, v}, 64'h0000_C000);
        wr(32'h00, 4, 32'h1B); wr(32'h10, 4, 64'h0100_0000);
        wr(32'h00, 4, 32'h1A); rd(32'h10, v);
        chk("R7 hi keeps", {32'h0, v}, 64'h0000_C000);
        wr(32'h10, 4, 64'h0000_8000); rd(32'h10, v);
        chk("R7 low clears", {32'h0, v}, 64'h0000_8000);
        pulse(6); chk("R7 edge no set", tbl_flat[6*64 +: 64], 64'h0001_0000);
        // R8
        cur_req = "R8";
        wr(32'h00, 4, 32'h10); wr(32'h10, 4, 64'h0001_0031);
        chk("R8 notify mask", {61'h0, mask_ntf_vld, mask_ntf_val, mask_ntf_idx == 0}, 64'h7);
        @(negedge clk); chk("R8 one cycle", {63'h0, mask_ntf_vld}, 64'h0);
        // R10
        cur_req = "R10";
        rd(32'h08, v); chk("R10 unknown", {32'h0, v}, 64'h0);
        rd(32'h20, v); chk("R10 unknown2", {32'h0, v}, 64'h0);
        wr(32'h01, 4, 64'h99); rd(32'h00, v);
        chk("R10 misaligned write", {32'h0, v}, 64'h10);
        done = 1;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule